// File: doc/BRIEF.md
# Programmable Top-Priority Interrupt Selector

This block decides which pending maskable interrupt request the CPU takes first. Each request line is tied to a fixed vector low byte. Source 0 is the external IRQ line at `$F2`. Each later source sits two bytes lower: `$F0`, `$EE`, and so on. Without any programming, a higher vector byte outranks a lower one.

Software can lift one source above all the others. It does this by writing that source's vector low byte into an 8-bit priority register. The register can only be written while the CPU's interrupt-mask flag is set, and it can be read at any time. If the stored value is above `$F2`, lies outside the implemented range, or names a vector that the build leaves out, the external IRQ stays on top and the default order holds.

The winner is resolved combinationally from the pending lines. The vector byte and the valid flag therefore follow the request inputs within the same cycle. The set of implemented vectors is a build-time mask, and pending lines of unimplemented sources are ignored.

Top module: `hprio_top`

## Requirements
- R1: After reset the priority register reads `$F2`, which puts the external IRQ first.
- R2: Bits 7 and 6 of the register always read 1 and bit 0 always reads 0. Bits 5..1 hold bits 5..1 of the last accepted write, so writing `$F1` reads back as `$F0`.
- R3: A write is accepted at a rising clock edge when `reg_we` is 1, `reg_addr` equals `$1F` and `irq_mask` is 1. The new value is visible on `reg_rdata` after that edge.
- R4: A write is ignored when `irq_mask` is 0 or when the address differs from `$1F`, and the register keeps its previous value.
- R5: Source i owns vector byte `$F2 - 2*i`, with source 0 (external IRQ) at `$F2`. `int_valid` is 1 exactly when at least one implemented source is pending.
- R6: When the promoted source is not pending, the winner is the pending implemented source with the highest vector byte.
- R7: A promoted source that is valid, implemented and pending wins over every other source, including the external IRQ.
- R8: If the register value is above `$F2`, below the lowest implemented range, or names an unimplemented vector, no source is promoted and the result equals the default order with IRQ first.
- R9: A pending bit of a source whose `IMPL_MASK` bit is 0 never produces a grant and never raises `int_valid`.
- R10: `int_vec` and `int_valid` follow a change of `pend` in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| irq_mask | input | 1 | CPU interrupt-mask flag; 1 means interrupts are inhibited |
| pend | input | NUM_SRC | Pending maskable requests; bit 0 is the external IRQ |
| reg_rdata | output | 8 | Priority register read value |
| int_valid | output | 1 | At least one implemented request is pending |
| int_vec | output | 8 | Vector low byte of the winning source |

## Verification
Two functions can act in the same cycle: a register write that changes the promoted source, and the combinational resolution of requests that are already pending. The bench holds `pend` constant across a qualified write. It then checks that the grant moves to the new promoted source right after the write edge.

In a second case the bench drives a write with the mask flag clear while a request is pending. It checks that both the register and the grant stay where they were. The checker ties the grant to the read-back register value every cycle, so a stale promotion is caught at the moment it occurs.

// File: rtl/hprio_pkg.sv
package hprio_pkg;

   // Highest supported source count: vector bytes must stay within $C0..$F2
   localparam int unsigned MAX_SRC = 26;

   // Vector low byte owned by a given source index
   function automatic logic [7:0] src_vec(input logic [7:0] top, input int unsigned idx);
      return top - 8'(2 * idx);
   endfunction

   // Arbiter variants
   localparam int unsigned ARB_LOOP = 0;
   localparam int unsigned ARB_ISOLATE = 1;

endpackage

// File: rtl/hprio_sel_reg.sv
module hprio_sel_reg #(
   parameter int unsigned        ADDR_W   = 8,
   parameter logic [ADDR_W-1:0]  REG_ADDR = 'h1F,
   parameter logic [7:0]         TOP_VEC  = 8'hF2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic              imask,
   output logic [7:0]        rdata,
   output logic [4:0]        sel
);

   localparam logic [4:0] SEL_RST = TOP_VEC[5:1];

   logic       hit;
   logic [4:0] sel_q;

   assign hit = we && (addr == REG_ADDR) && imask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= SEL_RST;
      end else if (hit) begin
         sel_q <= wdata[5:1];
      end
   end

   assign sel   = sel_q;
   assign rdata = {2'b11, sel_q, 1'b0};

endmodule

// File: rtl/hprio_promote_dec.sv
module hprio_promote_dec #(
   parameter int unsigned           NUM_SRC  = 16,
   parameter logic [7:0]            TOP_VEC  = 8'hF2,
   parameter logic [NUM_SRC-1:0]    IMPL_MASK = '1
) (
   input  logic [4:0]         sel,
   output logic [NUM_SRC-1:0] promo_oh,
   output logic               promo_ok
);

   logic [7:0]         val;
   logic [7:0]         diff;
   logic [6:0]         idx;
   logic               in_top;
   logic [NUM_SRC-1:0] match;

   assign val    = {2'b11, sel, 1'b0};
   assign in_top = (val <= TOP_VEC);
   assign diff   = TOP_VEC - val;
   assign idx    = diff[7:1];

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_match
      if (IMPL_MASK[i]) begin : g_impl
         assign match[i] = in_top && (idx == 7'(i));
      end else begin : g_hole
         assign match[i] = 1'b0;
      end
   end

   assign promo_ok = |match;

   always_comb begin
      promo_oh = match;
      if (!promo_ok) begin
         promo_oh    = '0;
         promo_oh[0] = 1'b1;   // fallback: external IRQ on top
      end
   end

endmodule

// File: rtl/hprio_arb.sv
module hprio_arb #(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned VARIANT = 0
) (
   input  logic [NUM_SRC-1:0] req,
   input  logic [NUM_SRC-1:0] promo_oh,
   output logic [NUM_SRC-1:0] grant_oh,
   output logic               any
);

   logic [NUM_SRC-1:0] hit;
   logic [NUM_SRC-1:0] first;

   assign hit = req & promo_oh;
   assign any = |req;

   if (VARIANT == hprio_pkg::ARB_LOOP) begin : g_loop
      always_comb begin
         first = '0;
         for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
               first    = '0;
               first[i] = 1'b1;
            end
         end
      end
   end else begin : g_isolate
      assign first = req & (~req + NUM_SRC'(1));
   end

   assign grant_oh = (|hit) ? hit : first;

endmodule

// File: rtl/hprio_vec_enc.sv
module hprio_vec_enc #(
   parameter int unsigned NUM_SRC = 16,
   parameter logic [7:0]  TOP_VEC = 8'hF2
) (
   input  logic [NUM_SRC-1:0] grant_oh,
   output logic [7:0]         vec
);

   logic [7:0] term [NUM_SRC];

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_term
      localparam logic [7:0] V = hprio_pkg::src_vec(TOP_VEC, i);
      assign term[i] = grant_oh[i] ? V : 8'h00;
   end

   always_comb begin
      vec = 8'h00;
      for (int i = 0; i < NUM_SRC; i++) begin
         vec = vec | term[i];
      end
   end

endmodule

// File: rtl/hprio_top.sv
module hprio_top #(
   parameter int unsigned        NUM_SRC   = 16,
   parameter int unsigned        ADDR_W    = 8,
   parameter logic [ADDR_W-1:0]  REG_ADDR  = 'h1F,
   parameter logic [7:0]         TOP_VEC   = 8'hF2,
   parameter logic [NUM_SRC-1:0] IMPL_MASK = 16'hFEFF,
   parameter int unsigned        ARB_VARIANT = hprio_pkg::ARB_ISOLATE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [7:0]         reg_wdata,
   input  logic               irq_mask,
   input  logic [NUM_SRC-1:0] pend,
   output logic [7:0]         reg_rdata,
   output logic               int_valid,
   output logic [7:0]         int_vec
);

   localparam int unsigned LOW_VEC = 32'(TOP_VEC) - 2 * (NUM_SRC - 1);

   if (NUM_SRC < 1 || NUM_SRC > hprio_pkg::MAX_SRC) begin : g_bad_count
      $error("hprio_top: NUM_SRC out of range");
   end
   if (TOP_VEC[7:6] != 2'b11 || TOP_VEC[0] != 1'b0) begin : g_bad_top
      $error("hprio_top: TOP_VEC must be even and at least $C0");
   end
   if (LOW_VEC < 32'hC0) begin : g_bad_low
      $error("hprio_top: lowest vector falls below $C0");
   end
   if (IMPL_MASK[0] != 1'b1) begin : g_bad_irq
      $error("hprio_top: external IRQ source must be implemented");
   end

   logic [4:0]         sel;
   logic [NUM_SRC-1:0] promo_oh;
   logic               promo_ok;
   logic [NUM_SRC-1:0] req;
   logic [NUM_SRC-1:0] grant_oh;

   hprio_sel_reg #(
      .ADDR_W  (ADDR_W),
      .REG_ADDR(REG_ADDR),
      .TOP_VEC (TOP_VEC)
   ) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (reg_we),
      .addr (reg_addr),
      .wdata(reg_wdata),
      .imask(irq_mask),
      .rdata(reg_rdata),
      .sel  (sel)
   );

   hprio_promote_dec #(
      .NUM_SRC  (NUM_SRC),
      .TOP_VEC  (TOP_VEC),
      .IMPL_MASK(IMPL_MASK)
   ) u_dec (
      .sel     (sel),
      .promo_oh(promo_oh),
      .promo_ok(promo_ok)
   );

   assign req = pend & IMPL_MASK;

   hprio_arb #(
      .NUM_SRC(NUM_SRC),
      .VARIANT(ARB_VARIANT)
   ) u_arb (
      .req     (req),
      .promo_oh(promo_oh),
      .grant_oh(grant_oh),
      .any     (int_valid)
   );

   hprio_vec_enc #(
      .NUM_SRC(NUM_SRC),
      .TOP_VEC(TOP_VEC)
   ) u_enc (
      .grant_oh(grant_oh),
      .vec     (int_vec)
   );

   logic unused_ok;
   assign unused_ok = promo_ok;

endmodule

// File: rtl/hprio_chk.sv
module hprio_chk #(
   parameter int unsigned        NUM_SRC   = 16,
   parameter int unsigned        ADDR_W    = 8,
   parameter logic [ADDR_W-1:0]  REG_ADDR  = 'h1F,
   parameter logic [7:0]         TOP_VEC   = 8'hF2,
   parameter logic [NUM_SRC-1:0] IMPL_MASK = '1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_we,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [7:0]         reg_wdata,
   input logic               irq_mask,
   input logic [NUM_SRC-1:0] pend,
   input logic [7:0]         reg_rdata,
   input logic               int_valid,
   input logic [7:0]         int_vec
);

   logic wr_ok;
   logic win_legal;
   logic promo_live;

   assign wr_ok = reg_we && (reg_addr == REG_ADDR) && irq_mask;

   always_comb begin
      win_legal  = 1'b0;
      promo_live = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (int_vec == hprio_pkg::src_vec(TOP_VEC, i) && pend[i] && IMPL_MASK[i])
            win_legal = 1'b1;
         if (reg_rdata == hprio_pkg::src_vec(TOP_VEC, i) && pend[i] && IMPL_MASK[i])
            promo_live = 1'b1;
      end
   end

   assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (reg_rdata[7:6] == 2'b11 && reg_rdata[0] == 1'b0));

   assert_write_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> (reg_rdata[5:1] == $past(reg_wdata[5:1])));

   assert_write_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ok |=> $stable(reg_rdata));

   assert_valid_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (int_valid == |(pend & IMPL_MASK)));

   assert_winner_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      int_valid |-> win_legal);

   assert_promoted_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      promo_live |-> (int_vec == reg_rdata));

endmodule

bind hprio_top hprio_chk #(
   .NUM_SRC  (NUM_SRC),
   .ADDR_W   (ADDR_W),
   .REG_ADDR (REG_ADDR),
   .TOP_VEC  (TOP_VEC),
   .IMPL_MASK(IMPL_MASK)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_we   (reg_we),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .irq_mask (irq_mask),
   .pend     (pend),
   .reg_rdata(reg_rdata),
   .int_valid(int_valid),
   .int_vec  (int_vec)
);

// File: tb/tb_hprio_top.sv
module tb_hprio_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [7:0]  reg_wdata = 8'h00;
   logic        irq_mask = 1'b0;
   logic [15:0] pend = 16'h0000;
   logic [7:0]  reg_rdata;
   logic        int_valid;
   logic [7:0]  int_vec;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   hprio_top dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_we   (reg_we),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .irq_mask (irq_mask),
      .pend     (pend),
      .reg_rdata(reg_rdata),
      .int_valid(int_valid),
      .int_vec  (int_vec)
   );

   // {write value, pend, exp valid, exp vec, exp readback}; source 8 ($E2) unimplemented
   localparam int NV = 13;
   localparam logic [40:0] TBL [NV] = '{
      {8'hF2, 16'h0000, 1'b0, 8'h00, 8'hF2},  // R5 nothing pending
      {8'hF2, 16'h0001, 1'b1, 8'hF2, 8'hF2},  // R5 IRQ alone
      {8'hF2, 16'h0006, 1'b1, 8'hF0, 8'hF2},  // R6 default order
      {8'hF0, 16'h0003, 1'b1, 8'hF0, 8'hF0},  // R7 promoted beats IRQ
      {8'hF0, 16'h0001, 1'b1, 8'hF2, 8'hF0},  // R6 promoted idle
      {8'hE6, 16'h8041, 1'b1, 8'hE6, 8'hE6},  // R7 mid source promoted
      {8'hFA, 16'h0006, 1'b1, 8'hF0, 8'hFA},  // R8 above top
      {8'hFA, 16'h0005, 1'b1, 8'hF2, 8'hFA},  // R8 IRQ first
      {8'hE2, 16'h0110, 1'b1, 8'hEA, 8'hE2},  // R8 R9 hole named
      {8'hE2, 16'h0100, 1'b0, 8'h00, 8'hE2},  // R9 hole pending only
      {8'hC0, 16'h8000, 1'b1, 8'hD4, 8'hC0},  // R8 below range
      {8'hD4, 16'hFEFF, 1'b1, 8'hD4, 8'hD4},  // R7 lowest promoted
      {8'hF1, 16'h0003, 1'b1, 8'hF0, 8'hF0}   // R2 bit 0 dropped
   };

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic m);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d; irq_mask = m;
      @(negedge clk);
      reg_we = 1'b0; irq_mask = 1'b0;
   endtask

   initial begin
      #4_000_000;
      n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check8("R1 reset readback", reg_rdata, 8'hF2);
      rst_n = 1'b1;
      @(negedge clk);
      check8("R1 after release", reg_rdata, 8'hF2);

      for (int k = 0; k < NV; k++) begin
         wr(8'h1F, TBL[k][40:33], 1'b1);
         pend = TBL[k][32:17];
         #2;
         check8("R3 R2 readback", reg_rdata, TBL[k][7:0]);
         check8("R5 valid", {7'd0, int_valid}, {7'd0, TBL[k][16]});
         if (TBL[k][16]) check8("R6 R7 R8 vector", int_vec, TBL[k][15:8]);
      end

      // R4: mask clear, write ignored while a request waits
      wr(8'h1F, 8'hF2, 1'b1);
      pend = 16'h0003;
      wr(8'h1F, 8'hF0, 1'b0);
      #2;
      check8("R4 mask clear readback", reg_rdata, 8'hF2);
      check8("R4 mask clear grant", int_vec, 8'hF2);
      // R4: wrong address ignored
      wr(8'h1E, 8'hF0, 1'b1);
      #2;
      check8("R4 wrong address", reg_rdata, 8'hF2);
      // R3: write lands while requests held, grant moves after edge
      wr(8'h1F, 8'hF0, 1'b1);
      #2;
      check8("R3 grant follows write", int_vec, 8'hF0);
      // R10: combinational response between edges
      @(negedge clk);
      #3;
      pend = 16'h0004;
      #1;
      check8("R10 same-cycle vector", int_vec, 8'hEE);
      pend = 16'h0000;
      #1;
      check8("R10 same-cycle idle", {7'd0, int_valid}, 8'h00);
      // R1: reset restores default
      rst_n = 1'b0;
      #2;
      check8("R1 async reset", reg_rdata, 8'hF2);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule